// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a just-received CAN frame should be handed to the host. Each frame first lands in a background receive buffer. When reception completes, the block compares the frame's four-byte identifier image against two banks of programmable acceptance codes. Each bank has its own mask bytes, and a mask bit set to 1 makes the matching identifier bit a don't-care.

If either bank matches, the block raises an accept flag and a receive-ready pulse to the host, and reports the lowest-numbered bank that matched. A frame that fails both banks produces no indication at all. It simply stays in the background buffer until the next frame overwrites it.

Extended-format frames are judged on all four identifier bytes. Standard-format frames are judged on the first two only. The code and mask bytes sit behind a small register port. They can be read at any time, but writes take effect only while the controller is in initialization mode, meaning both the request and the acknowledge are high.

Top module: `can_id_filter`

## Requirements
- R1: After reset every code byte and every mask byte reads 0, and `accept_o`, `rx_ready_o` and `hit_bank_o` are 0.
- R2: A write on the register port changes the addressed byte only when `wr_en_i`, `init_req_i` and `init_ack_i` are all 1 at the clock edge. In every other case no byte changes.
- R3: `rd_data_o` combinationally returns the byte selected by `rd_addr_i` in any mode. The address layout is the same for reads and writes: bit 3 chooses mask (1) or code (0), bit 2 chooses the bank, and bits 1:0 choose the identifier byte. Identifier byte k is `id_i[8k+7:8k]`.
- R4: For an extended frame (`ext_i`=1), a bank matches when every identifier bit across all four bytes equals its code bit, except where the corresponding mask bit is 1 (don't-care).
- R5: For a standard frame (`ext_i`=0), only identifier bytes 0 and 1 are compared. The contents of bytes 2 and 3, and of their code and mask bytes, have no effect on the decision.
- R6: A frame is accepted if at least one bank matches. `hit_bank_o` gives the lowest-numbered matching bank.
- R7: `accept_o` and `rx_ready_o` are both high for exactly one cycle, in the cycle after the edge that samples `frame_done_i`=1, and only for accepted frames. For rejected frames they stay low.
- R8: The identifier and format flag are evaluated only at the edge where `frame_done_i` is 1. Changes to them at other times raise no output.
- R9: `hit_bank_o` is 0 whenever `accept_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_i | input | 32 | Identifier image from the background buffer, byte k at bits 8k+7:8k |
| ext_i | input | 1 | 1 = extended frame, 0 = standard frame |
| frame_done_i | input | 1 | Frame-complete strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Write address (mask/code, bank, byte) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address, same layout as the write address |
| rd_data_o | output | 8 | Read data |
| init_req_i | input | 1 | Initialization-mode request |
| init_ack_i | input | 1 | Initialization-mode acknowledge |
| accept_o | output | 1 | Frame accepted (one-cycle pulse) |
| hit_bank_o | output | 1 | Lowest matching bank |
| rx_ready_o | output | 1 | Receive-ready pulse to the host |

## Verification
The assertions check four behaviours on every cycle:
- the register contents freeze outside initialization mode;
- a ready pulse only ever follows a strobe;
- a strobe with no bank hit yields no pulse;
- the reported bank is the lowest hit and reads 0 when nothing is accepted.

The correctness of the match itself is shown only by the bench's scenarios. These cover exact and masked bit compares, standard frames with junk in the upper bytes, both banks hitting, and random frames biased toward near-matches, all checked against a bench model of the register contents.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int ID_BYTES  = 4;
  localparam int STD_BYTES = 2;
  localparam int BYTE_W    = 8;
  localparam int BYTE_IDX_W = $clog2(ID_BYTES);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int ADDR_W    = 4
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    wr_en_i,
  input  logic [ADDR_W-1:0]                       wr_addr_i,
  input  byte_t                                   wr_data_i,
  input  logic [ADDR_W-1:0]                       rd_addr_i,
  output byte_t                                   rd_data_o,
  input  logic                                    init_req_i,
  input  logic                                    init_ack_i,
  output logic [NUM_BANKS-1:0][ID_BYTES-1:0][BYTE_W-1:0] code_o,
  output logic [NUM_BANKS-1:0][ID_BYTES-1:0][BYTE_W-1:0] mask_o
);
  logic [NUM_BANKS-1:0][ID_BYTES-1:0][BYTE_W-1:0] code_q, mask_q;
  logic                  wr_ok;
  logic                  wr_sel_mask, rd_sel_mask;
  logic [BANK_W-1:0]     wr_bank, rd_bank;
  logic [BYTE_IDX_W-1:0] wr_byte, rd_byte;

  assign wr_ok       = wr_en_i & init_req_i & init_ack_i;
  assign wr_sel_mask = wr_addr_i[ADDR_W-1];
  assign wr_bank     = wr_addr_i[BYTE_IDX_W +: BANK_W];
  assign wr_byte     = wr_addr_i[BYTE_IDX_W-1:0];
  assign rd_sel_mask = rd_addr_i[ADDR_W-1];
  assign rd_bank     = rd_addr_i[BYTE_IDX_W +: BANK_W];
  assign rd_byte     = rd_addr_i[BYTE_IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < ID_BYTES; k++) begin : g_byte
      logic hit_this;
      assign hit_this = wr_ok && (32'(wr_bank) == b) && (32'(wr_byte) == k);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          code_q[b][k] <= '0;
          mask_q[b][k] <= '0;
        end else if (hit_this) begin
          if (wr_sel_mask) mask_q[b][k] <= wr_data_i;
          else             code_q[b][k] <= wr_data_i;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_bank) < NUM_BANKS) begin
      rd_data_o = rd_sel_mask ? mask_q[rd_bank][rd_byte] : code_q[rd_bank][rd_byte];
    end
  end

  assign code_o = code_q;
  assign mask_o = mask_q;

  AST_WR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_req_i && init_ack_i) |=> ($stable(code_q) && $stable(mask_q))); // R2
endmodule

// File: rtl/can_flt_bank_match.sv
module can_flt_bank_match
  import can_flt_pkg::*;
(
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] id_i,
  input  logic                            ext_i,
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] code_i,
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] mask_i,
  output logic                            hit_o
);
  logic [ID_BYTES-1:0] byte_ok;

  for (genvar k = 0; k < ID_BYTES; k++) begin : g_cmp
    localparam bit ALWAYS_USED = (k < STD_BYTES);
    logic  used;
    byte_t diff;
    assign used       = ALWAYS_USED ? 1'b1 : ext_i;
    // mask bit 1 = don't-care
    assign diff       = (id_i[k] ^ code_i[k]) & ~mask_i[k];
    assign byte_ok[k] = !used || (diff == '0);
  end

  assign hit_o = &byte_ok;
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic [NUM_BANKS-1:0] hit_i,
  output logic                 accept_o,
  output logic                 ready_o,
  output logic [BANK_W-1:0]    bank_o
);
  logic [BANK_W-1:0] low_idx;
  logic              any_hit, take;

  always_comb begin
    low_idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hit_i[b]) low_idx = BANK_W'(b);
    end
  end

  assign any_hit = |hit_i;
  assign take    = strobe_i & any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      ready_o  <= 1'b0;
      bank_o   <= '0;
    end else begin
      accept_o <= take;
      ready_o  <= take;
      bank_o   <= take ? low_idx : '0;
    end
  end

  AST_READY_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(strobe_i)); // R7
  AST_REJECT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !any_hit) |=> (!ready_o && !accept_o)); // R7
  AST_LOWEST_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && bank_o != '0) |-> !$past(hit_i[0])); // R6
  AST_IDLE_BANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (bank_o == '0)); // R9
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = 1 + BANK_W + BYTE_IDX_W,
  localparam int ID_W     = ID_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   id_i,
  input  logic              ext_i,
  input  logic              frame_done_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              init_req_i,
  input  logic              init_ack_i,
  output logic              accept_o,
  output logic [BANK_W-1:0] hit_bank_o,
  output logic              rx_ready_o
);
  logic [NUM_BANKS-1:0][ID_BYTES-1:0][BYTE_W-1:0] code_w, mask_w;
  logic [ID_BYTES-1:0][BYTE_W-1:0]                id_bytes;
  logic [NUM_BANKS-1:0]                           bank_hit;

  assign id_bytes = id_i;

  can_flt_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .init_req_i (init_req_i),
    .init_ack_i (init_ack_i),
    .code_o     (code_w),
    .mask_o     (mask_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    can_flt_bank_match u_match (
      .id_i   (id_bytes),
      .ext_i  (ext_i),
      .code_i (code_w[b]),
      .mask_i (mask_w[b]),
      .hit_o  (bank_hit[b])
    );
  end

  can_flt_prio #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_prio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (frame_done_i),
    .hit_i    (bank_hit),
    .accept_o (accept_o),
    .ready_o  (rx_ready_o),
    .bank_o   (hit_bank_o)
  );

  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> (!accept_o && !rx_ready_o)); // R8
endmodule

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] id_i = '0;
  logic        ext_i = 1'b0;
  logic        frame_done_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        init_req_i = 1'b0;
  logic        init_ack_i = 1'b0;
  logic        accept_o;
  logic [0:0]  hit_bank_o;
  logic        rx_ready_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_code [2][4];
  logic [7:0] m_mask [2][4];

  always #2.5 clk_i = ~clk_i;

  can_id_filter dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hits(input logic [31:0] id, input logic ext);
    logic [1:0] h;
    for (int b = 0; b < 2; b++) begin
      h[b] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (ext || k < 2)
          if (((id[8*k +: 8] ^ m_code[b][k]) & ~m_mask[b][k]) != 8'h00) h[b] = 1'b0;
      end
    end
    return h;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic rq, input logic ak);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; init_req_i = rq; init_ack_i = ak;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (rq && ak) begin
      if (a[3]) m_mask[a[2]][a[1:0]] = d;
      else      m_code[a[2]][a[1:0]] = d;
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    logic [7:0] e;
    rd_addr_i = a;
    #0.5;
    e = a[3] ? m_mask[a[2]][a[1:0]] : m_code[a[2]][a[1:0]];
    chk(rd_data_o === e, tag, rd_data_o, e);
  endtask

  task automatic frame(input logic [31:0] id, input logic ext, input string tag);
    logic [1:0] h;
    logic       ea;
    logic       eb;
    @(negedge clk_i);
    id_i = id; ext_i = ext; frame_done_i = 1'b1;
    h  = exp_hits(id, ext);
    ea = |h;
    eb = ea && !h[0];
    @(negedge clk_i);
    frame_done_i = 1'b0;
    chk(accept_o === ea,   {tag, " R7 accept"}, accept_o, ea);
    chk(rx_ready_o === ea, {tag, " R7 ready"},  rx_ready_o, ea);
    chk(hit_bank_o === eb, {tag, " R6/R9 bank"}, hit_bank_o, eb);
    id_i = $urandom; ext_i = $urandom_range(0, 1);
    @(negedge clk_i);
    chk(rx_ready_o === 1'b0 && accept_o === 1'b0, {tag, " R7/R8 pulse end"}, rx_ready_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] id;
    void'($urandom(32'h5eed_c0de));
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++) begin m_code[b][k] = 0; m_mask[b][k] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(accept_o === 0 && rx_ready_o === 0 && hit_bank_o === 0, "R1 outputs", accept_o, 0);
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R1 reset byte");

    // R2 blocked writes
    wr(4'h0, 8'hA5, 1'b1, 1'b0); rd_chk(4'h0, "R2 req only");
    wr(4'h9, 8'h3C, 1'b0, 1'b1); rd_chk(4'h9, "R2 ack only");
    wr(4'h5, 8'h77, 1'b0, 1'b0); rd_chk(4'h5, "R2 none");

    // R3 init-mode writes, readback outside init mode
    wr(4'h0, 8'h12, 1, 1); wr(4'h1, 8'h34, 1, 1); wr(4'h2, 8'h56, 1, 1); wr(4'h3, 8'h78, 1, 1);
    wr(4'h4, 8'h9A, 1, 1); wr(4'h5, 8'hBC, 1, 1); wr(4'h6, 8'hDE, 1, 1); wr(4'h7, 8'hF0, 1, 1);
    init_req_i = 0; init_ack_i = 0;
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R3 readback");

    // R4 extended exact match and single-bit miss
    frame(32'h7856_3412, 1'b1, "R4 exact bank0");
    frame(32'h7956_3412, 1'b1, "R4 one-bit miss");
    wr(4'hB, 8'h01, 1, 1);
    frame(32'h7956_3412, 1'b1, "R4 masked bit");
    // R5 standard ignores bytes 2/3
    frame(32'hFFFF_3412, 1'b0, "R5 std junk upper");
    frame(32'hFFFF_3412, 1'b1, "R5 ext same id rejects");
    frame(32'h0000_BC9A, 1'b0, "R5 std bank1 only");
    // R6 both banks hit -> bank 0
    wr(4'h4, 8'h12, 1, 1); wr(4'h5, 8'h34, 1, 1);
    frame(32'hAAAA_3412, 1'b0, "R6 both hit");
    frame(32'hF0DE_3412, 1'b1, "R6 ext bank1 only");
    // R8 no strobe: wiggle inputs
    @(negedge clk_i); id_i = 32'h7856_3412; ext_i = 1;
    @(negedge clk_i); @(negedge clk_i);
    chk(accept_o === 0 && rx_ready_o === 0, "R8 no strobe", rx_ready_o, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [3:0] a;
        logic rq, ak;
        a  = 4'($urandom);
        rq = ($urandom_range(0, 3) != 0);
        ak = ($urandom_range(0, 3) != 0);
        wr(a, 8'($urandom), rq, ak);
        rd_chk(a, "R2/R3 random write");
      end else begin
        int b;
        b  = $urandom_range(0, 1);
        id = $urandom;
        if ($urandom_range(0, 1) == 1) begin
          for (int k = 0; k < 4; k++)
            id[8*k +: 8] = m_code[b][k] ^ (8'($urandom) & m_mask[b][k]);
          if ($urandom_range(0, 3) == 0) id[$urandom_range(0, 31)] ^= 1'b1;
        end
        frame(id, 1'($urandom_range(0, 1)), "R4/R5/R6 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule